// File: doc/BRIEF.md
# Locality Ownership Arbiter

This block decides which of five requesters, called localities, owns a single shared command interface. Each locality sees its own byte-wide access register, picked by a 3-bit select. Writing that register is how a locality asks for the interface, gives it back, or takes it by force from a lower-numbered owner. Reading it returns the locality's flags, plus a computed bit that shows whether anyone else is waiting.

The arbiter holds the owner index and, for each locality, a request flag, a seize flag and a sticky seized-from flag. A change of owner raises a one-cycle event tagged with the new owner. A busy input from the command engine defers any handover to a locality until the command in flight has finished. Releasing to nobody and a first grant into an idle interface are not deferred.

Register bit positions, used for both read and write: bit 7 register-valid (always reads 1), bit 5 active, bit 4 seized-from, bit 3 seize (write only), bit 2 others-waiting (read only), bit 1 request. Bits 6 and 0 read 0.

Top module: `locarb_top`

## Requirements
- R1: After reset, owner_id is 0xFF (no owner), loc_chg is low, and every locality 0..4 reads 0x80.
- R2: A request write (bit 1) while nobody owns the interface and no handover is held grants ownership at that clock edge, even with busy high.
- R3: A request write while another locality owns the interface only sets the writer's request bit. Bit 2 of a locality's readback is 1 when any other locality has its request bit set.
- R4: An active-bit write (bit 5) from the owner releases it. Ownership goes to the highest-numbered locality with its request bit set. If none is waiting, owner_id becomes 0xFF with no event.
- R5: An active-bit write from a locality that is not the owner clears that locality's request bit.
- R6: A seize write (bit 3) is accepted only when there is no owner or the writer's index is above the owner's. It is refused while the writer or any higher-numbered locality already has a seize pending. Acceptance clears the pending seizes of all lower-numbered localities, and the seizing locality becomes owner.
- R7: A locality that loses ownership to a seize has its active bit cleared, keeps its request bit, and gets the sticky seized-from bit (bit 4). Writing 1 to bit 4 clears it.
- R8: The new owner reads with active set and its request bit cleared; at most one locality is active.
- R9: Bit 3 always reads 0.
- R10: In a write with bit 3 set, bits 1 and 5 are ignored.
- R11: Writes with select 4, and with selects 5..7, change nothing. Selects 5..7 read 0xFF.
- R12: Every change to a valid owner pulses loc_chg for one cycle, with loc_chg_id equal to the new owner.
- R13: While busy is high, a release-to-waiter or a seize handover is held and owner_id does not change. It completes at the first clock edge at which busy is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_wr | input | 1 | Write strobe for the selected access register |
| acc_sel | input | 3 | Locality select (address bits 14:12) |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Readback of the selected register (combinational) |
| busy | input | 1 | Command in flight; defers handovers |
| owner_id | output | 8 | Current owner index, 0xFF when none |
| loc_chg | output | 1 | One-cycle owner-changed event |
| loc_chg_id | output | 3 | New owner accompanying loc_chg |

## Verification
The hardest state to reach is a held seize that is overridden or contested while busy stays high. This needs an owner, busy high across several writes, and seizes arriving from localities above and below the pending one. Directed sequences build this state on purpose: a refusal because a higher seize is pending, followed by completion when busy drops. Random traffic with busy high about a third of the time then reaches overlapping holds, releases and request grants. A bench model computes the expected owner, event and readback of all eight selects after every cycle.

// File: rtl/locarb_pkg.sv
package locarb_pkg;
  localparam int unsigned BIT_VALID = 7;
  localparam int unsigned BIT_ACT   = 5;
  localparam int unsigned BIT_BSZ   = 4;
  localparam int unsigned BIT_SEIZE = 3;
  localparam int unsigned BIT_PEND  = 2;
  localparam int unsigned BIT_REQ   = 1;
  localparam logic [7:0]  NO_OWNER  = 8'hFF;
  localparam logic [7:0]  BAD_SEL   = 8'hFF;
endpackage

// File: rtl/locarb_pick.sv
module locarb_pick #(
  parameter int NUM_LOC = 5,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_LOC-1:0] vec,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/locarb_seize_gate.sv
module locarb_seize_gate #(
  parameter int NUM_LOC = 5,
  parameter int IDX_W   = 3
) (
  input  logic [IDX_W-1:0]   wsel,
  input  logic [NUM_LOC-1:0] seize_q,
  input  logic               own_vld,
  input  logic [IDX_W-1:0]   own_idx,
  output logic               accept,
  output logic [NUM_LOC-1:0] lower_mask
);
  logic higher_pending;

  always_comb begin
    higher_pending = 1'b0;
    lower_mask     = '0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (i > int'(wsel)) higher_pending = higher_pending | seize_q[i];
      if (i < int'(wsel)) lower_mask[i] = 1'b1;
    end
  end

  assign accept = (!own_vld || (wsel > own_idx)) && !seize_q[wsel] && !higher_pending;
endmodule

// File: rtl/locarb_readback.sv
module locarb_readback
  import locarb_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int SEL_W   = 3
) (
  input  logic [SEL_W-1:0]   sel,
  input  logic [NUM_LOC-1:0] act,
  input  logic [NUM_LOC-1:0] bsz,
  input  logic [NUM_LOC-1:0] req,
  output logic [7:0]         rdata
);
  logic others;

  always_comb begin
    others = 1'b0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (i != int'(sel)) others = others | req[i];
    end
    rdata = BAD_SEL;
    if (int'(sel) < NUM_LOC) begin
      rdata            = '0;
      rdata[BIT_VALID] = 1'b1;
      rdata[BIT_ACT]   = act[sel];
      rdata[BIT_BSZ]   = bsz[sel];
      rdata[BIT_PEND]  = others;
      rdata[BIT_REQ]   = req[sel];
    end
  end
endmodule

// File: rtl/locarb_top.sv
module locarb_top
  import locarb_pkg::*;
#(
  parameter int NUM_LOC    = 5,
  parameter int SEL_W      = 3,
  parameter int LOCKED_LOC = NUM_LOC - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_wr,
  input  logic [SEL_W-1:0] acc_sel,
  input  logic [7:0]       acc_wdata,
  output logic [7:0]       acc_rdata,
  input  logic             busy,
  output logic [7:0]       owner_id,
  output logic             loc_chg,
  output logic [SEL_W-1:0] loc_chg_id
);
  localparam int IDX_W = $clog2(NUM_LOC);

  logic [NUM_LOC-1:0] act_q, req_q, sz_q, bsz_q;
  logic [NUM_LOC-1:0] n_act, n_req, n_sz, n_bsz;
  logic [IDX_W-1:0]   own_q, n_own, htgt_q, n_htgt, chgid_q, n_chgid;
  logic               own_vld_q, n_vld, hold_q, n_hold, hsz_q, n_hsz, chg_q, n_chg;

  logic [IDX_W-1:0]   wsel;
  logic               wr_ok, is_owner;
  logic               pick_found;
  logic [IDX_W-1:0]   pick_idx;
  logic               seize_ok;
  logic [NUM_LOC-1:0] lower_mask;

  assign wsel     = acc_sel[IDX_W-1:0];
  assign wr_ok    = acc_wr && (int'(acc_sel) < NUM_LOC) && (int'(acc_sel) != LOCKED_LOC);
  assign is_owner = own_vld_q && (own_q == wsel);

  locarb_pick #(.NUM_LOC(NUM_LOC), .IDX_W(IDX_W)) u_pick (
    .vec(req_q), .found(pick_found), .idx(pick_idx)
  );

  locarb_seize_gate #(.NUM_LOC(NUM_LOC), .IDX_W(IDX_W)) u_gate (
    .wsel(wsel), .seize_q(sz_q), .own_vld(own_vld_q), .own_idx(own_q),
    .accept(seize_ok), .lower_mask(lower_mask)
  );

  locarb_readback #(.NUM_LOC(NUM_LOC), .SEL_W(SEL_W)) u_rd (
    .sel(acc_sel), .act(act_q), .bsz(bsz_q), .req(req_q), .rdata(acc_rdata)
  );

  logic [7:0]       d;
  logic             cmd_v, cmd_sz, grant, drop;
  logic [IDX_W-1:0] cmd_t;
  logic             go_v, go_sz;
  logic [IDX_W-1:0] go_t;

  always_comb begin
    n_act = act_q; n_req = req_q; n_sz = sz_q; n_bsz = bsz_q;
    n_own = own_q; n_vld = own_vld_q;
    n_hold = hold_q; n_htgt = htgt_q; n_hsz = hsz_q;
    n_chg = 1'b0; n_chgid = chgid_q;
    cmd_v = 1'b0; cmd_t = '0; cmd_sz = 1'b0; grant = 1'b0; drop = 1'b0;

    d = acc_wdata;
    if (d[BIT_SEIZE]) begin
      d[BIT_REQ] = 1'b0;
      d[BIT_ACT] = 1'b0;
    end

    if (wr_ok) begin
      if (d[BIT_ACT]) begin
        if (is_owner) begin
          if (!hold_q) begin
            if (pick_found) begin
              cmd_v = 1'b1;
              cmd_t = pick_idx;
            end else begin
              drop = 1'b1;
            end
          end
        end else begin
          n_req[wsel] = 1'b0;
        end
      end
      if (d[BIT_BSZ]) n_bsz[wsel] = 1'b0;
      if (d[BIT_SEIZE] && seize_ok) begin
        n_sz       = sz_q & ~lower_mask;
        n_sz[wsel] = 1'b1;
        cmd_v      = 1'b1;
        cmd_t      = wsel;
        cmd_sz     = 1'b1;
      end
      if (d[BIT_REQ] && !is_owner) begin
        if (!own_vld_q && !hold_q && !cmd_v) begin
          cmd_v = 1'b1;
          cmd_t = wsel;
          grant = 1'b1;
        end else begin
          n_req[wsel] = 1'b1;
        end
      end
    end

    go_v  = cmd_v || hold_q;
    go_t  = cmd_v ? cmd_t  : htgt_q;
    go_sz = cmd_v ? cmd_sz : hsz_q;

    if (go_v && (!busy || grant)) begin
      if (own_vld_q && (own_q != go_t)) begin
        n_act[own_q] = 1'b0;
        if (go_sz) n_bsz[own_q] = 1'b1;
        else       n_req[own_q] = 1'b0;
      end
      n_own        = go_t;
      n_vld        = 1'b1;
      n_act[go_t]  = 1'b1;
      n_req[go_t]  = 1'b0;
      n_sz[go_t]   = 1'b0;
      n_hold       = 1'b0;
      if (!own_vld_q || (own_q != go_t)) begin
        n_chg   = 1'b1;
        n_chgid = go_t;
      end
    end else if (go_v) begin
      n_hold = 1'b1;
      n_htgt = go_t;
      n_hsz  = go_sz;
    end

    if (drop) begin
      n_act[own_q] = 1'b0;
      n_req[own_q] = 1'b0;
      n_vld        = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0; req_q <= '0; sz_q <= '0; bsz_q <= '0;
      own_q <= '0; own_vld_q <= 1'b0;
      hold_q <= 1'b0; htgt_q <= '0; hsz_q <= 1'b0;
      chg_q <= 1'b0; chgid_q <= '0;
    end else begin
      act_q <= n_act; req_q <= n_req; sz_q <= n_sz; bsz_q <= n_bsz;
      own_q <= n_own; own_vld_q <= n_vld;
      hold_q <= n_hold; htgt_q <= n_htgt; hsz_q <= n_hsz;
      chg_q <= n_chg; chgid_q <= n_chgid;
    end
  end

  assign owner_id   = own_vld_q ? 8'(own_q) : NO_OWNER;
  assign loc_chg    = chg_q;
  assign loc_chg_id = SEL_W'(chgid_q);
endmodule

// File: rtl/locarb_chk.sv
module locarb_chk #(
  parameter int NUM_LOC    = 5,
  parameter int SEL_W      = 3,
  parameter int LOCKED_LOC = NUM_LOC - 1,
  parameter int IDX_W      = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_wr,
  input logic [SEL_W-1:0]   acc_sel,
  input logic [7:0]         acc_rdata,
  input logic               busy,
  input logic [7:0]         owner_id,
  input logic               loc_chg,
  input logic [SEL_W-1:0]   loc_chg_id,
  input logic [NUM_LOC-1:0] act_q,
  input logic               hold_q
);
  p_single_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_q));

  p_owner_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_id != 8'hFF) |-> act_q[owner_id[IDX_W-1:0]]);

  p_seize_hidden_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(acc_sel) < NUM_LOC) |-> !acc_rdata[3]);

  p_locked_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && (int'(acc_sel) >= LOCKED_LOC) && !hold_q) |=> (!loc_chg && $stable(owner_id)));

  p_event_matches_r12: assert property (@(posedge clk) disable iff (!rst_n)
    loc_chg |-> (owner_id == 8'(loc_chg_id)));

  p_busy_holds_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hold_q) |=> $stable(owner_id));
endmodule

bind locarb_top locarb_chk #(
  .NUM_LOC(NUM_LOC), .SEL_W(SEL_W), .LOCKED_LOC(LOCKED_LOC), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_sel(acc_sel),
  .acc_rdata(acc_rdata), .busy(busy), .owner_id(owner_id),
  .loc_chg(loc_chg), .loc_chg_id(loc_chg_id), .act_q(act_q), .hold_q(hold_q)
);

// File: tb/locarb_top_test.sv
`timescale 1ns/100ps
module locarb_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_wr = 1'b0;
  logic [2:0] acc_sel = '0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] acc_rdata;
  logic       busy = 1'b0;
  logic [7:0] owner_id;
  logic       loc_chg;
  logic [2:0] loc_chg_id;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  locarb_top uut (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_sel(acc_sel),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .busy(busy),
    .owner_id(owner_id), .loc_chg(loc_chg), .loc_chg_id(loc_chg_id)
  );

  // reference state
  bit [4:0] m_req, m_sz, m_bsz;
  int m_own = -1;
  bit m_hold, m_hsz, m_chg;
  int m_htgt, m_chgid;

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_rd(input int s);
    int v;
    bit pend;
    if (s >= 5) return 8'hFF;
    pend = 1'b0;
    for (int i = 0; i < 5; i++) if (i != s && m_req[i]) pend = 1'b1;
    v = 8'h80 | ((m_own == s) ? 8'h20 : 0) | (m_bsz[s] ? 8'h10 : 0) |
        (pend ? 8'h04 : 0) | (m_req[s] ? 8'h02 : 0);
    return v;
  endfunction

  task automatic model_step(input bit w, input int s, input logic [7:0] din, input bit b);
    logic [7:0] d;
    bit ok, own_is, csz, grant, drop, hp, gsz;
    int ct, gt;
    d = din; ct = -1; csz = 0; grant = 0; drop = 0; m_chg = 0;
    ok = w && s < 5 && s != 4;
    own_is = (m_own == s);
    if (d[3]) begin d[1] = 0; d[5] = 0; end
    if (ok) begin
      if (d[5]) begin
        if (own_is) begin
          if (!m_hold) begin
            int hi;
            hi = -1;
            for (int i = 0; i < 5; i++) if (m_req[i]) hi = i;
            if (hi >= 0) ct = hi; else drop = 1;
          end
        end else m_req[s] = 0;
      end
      if (d[4]) m_bsz[s] = 0;
      if (d[3]) begin
        hp = 0;
        for (int i = s + 1; i < 5; i++) if (m_sz[i]) hp = 1;
        if ((m_own < 0 || s > m_own) && !m_sz[s] && !hp) begin
          for (int i = 0; i < s; i++) m_sz[i] = 0;
          m_sz[s] = 1; ct = s; csz = 1;
        end
      end
      if (d[1] && !own_is) begin
        if (m_own < 0 && !m_hold && ct < 0) begin ct = s; grant = 1; end
        else m_req[s] = 1;
      end
    end
    if (ct >= 0 || m_hold) begin
      gt  = (ct >= 0) ? ct : m_htgt;
      gsz = (ct >= 0) ? csz : m_hsz;
      if (!b || grant) begin
        if (m_own >= 0 && m_own != gt) begin
          if (gsz) m_bsz[m_own] = 1; else m_req[m_own] = 0;
        end
        if (m_own != gt) begin m_chg = 1; m_chgid = gt; end
        m_own = gt; m_req[gt] = 0; m_sz[gt] = 0; m_hold = 0;
      end else begin
        m_hold = 1; m_htgt = gt; m_hsz = gsz;
      end
    end
    if (drop) begin
      m_req[m_own] = 0;
      m_own = -1;
    end
  endtask

  task automatic step(input bit w, input int s, input logic [7:0] d, input bit b);
    @(negedge clk);
    acc_wr = w; acc_sel = 3'(s); acc_wdata = d; busy = b;
    @(posedge clk);
    #1;
    acc_wr = 1'b0;
    model_step(w, s, d, b);
    chk(owner_id, (m_own < 0) ? 8'hFF : m_own, "R2 R4 R6 R13 owner");
    chk(loc_chg, m_chg, "R12 event");
    if (m_chg) chk(loc_chg_id, m_chgid, "R12 event id");
    for (int i = 0; i < 8; i++) begin
      acc_sel = 3'(i);
      #0.3;
      chk(acc_rdata, exp_rd(i), "R3 R5 R7 R9 readback");
    end
  endtask

  task automatic rd(input int s, input int exp, input string tag);
    acc_sel = 3'(s);
    #0.1;
    chk(acc_rdata, exp, tag);
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #0.5;
    chk(owner_id, 8'hFF, "R1 owner");
    chk(loc_chg, 0, "R1 event");
    for (int i = 0; i < 5; i++) rd(i, 8'h80, "R1 reset read");

    step(1, 1, 8'h02, 1);                    // grant while unowned, busy high
    chk(owner_id, 1, "R2 grant"); chk(loc_chg_id, 1, "R12 id");
    rd(1, 8'hA0, "R8 new owner");
    step(1, 0, 8'h02, 0);
    chk(owner_id, 1, "R3 owner kept");
    rd(0, 8'h82, "R3 request bit"); rd(1, 8'hA4, "R3 pending bit");
    step(1, 2, 8'h02, 0);
    step(1, 0, 8'h20, 0);
    rd(0, 8'h84, "R5 request cleared");
    step(1, 0, 8'h02, 0);
    step(1, 1, 8'h20, 0);
    chk(owner_id, 2, "R4 highest waiter");
    rd(2, 8'hA4, "R8 request cleared");
    step(1, 4, 8'h08, 0);
    chk(owner_id, 2, "R11 locked write"); chk(loc_chg, 0, "R11 no event");
    rd(5, 8'hFF, "R11 bad select read");
    step(1, 6, 8'h02, 0);
    chk(owner_id, 2, "R11 bad select write");
    step(1, 1, 8'h08, 0);
    chk(owner_id, 2, "R6 lower seize refused");
    step(1, 0, 8'h28, 0);
    rd(0, 8'h82, "R10 active bit ignored");
    step(1, 3, 8'h08, 0);
    chk(owner_id, 3, "R6 seize accepted");
    rd(2, 8'h94, "R7 seized-from set"); rd(3, 8'hA4, "R9 seize hidden");
    step(1, 2, 8'h10, 0);
    rd(2, 8'h84, "R7 seized-from cleared");
    step(1, 3, 8'h20, 1);
    chk(owner_id, 3, "R13 held");
    step(0, 0, 8'h00, 1);
    chk(owner_id, 3, "R13 still held");
    step(0, 0, 8'h00, 0);
    chk(owner_id, 0, "R13 completes"); chk(loc_chg, 1, "R12 pulse");
    step(1, 3, 8'h08, 1);
    step(1, 2, 8'h08, 1);
    step(0, 0, 8'h00, 0);
    chk(owner_id, 3, "R6 higher seize pending wins");
    rd(0, 8'h90, "R7 seized owner flags");
    step(1, 3, 8'h20, 0);
    chk(owner_id, 8'hFF, "R4 release to none"); chk(loc_chg, 0, "R4 no event");

    for (int n = 0; n < 3000; n++) begin
      int s;
      logic [7:0] d;
      s = (($urandom % 8) == 0) ? int'($urandom % 8) : int'($urandom % 5);
      d = 8'($urandom);
      step(($urandom % 4) != 0, s, d, ($urandom % 3) == 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule